// File: doc/BRIEF.md
# Wormhole Packet Switch Core

This block is an input-buffered packet switch with a fixed number of ports (four by default). Packets arrive as a sequence of flits. The first flit is a header, and the last flit is marked as the tail. Every input port has a 10-entry buffer. When a header reaches the front of that buffer, the switch looks up the header's destination field in a small forwarding table to find the output port. The input then asks that output's round-robin arbiter for access. A granted input keeps its crossbar path until its tail flit has gone through. Body and tail flits follow the header's path without a new lookup. Each output drives its flits from a one-flit output register that has a valid/ready handshake.

Each flit passes through five steps in order: buffer write, route lookup, arbitration, crossbar traversal and output register load. Once a path is held, a port moves one flit per cycle. Several inputs can use different outputs at the same time. The forwarding table is written through a simple write port while no traffic is in flight.

Top module: `sw_core`

## Requirements
- R1: The 2-bit flit type uses bit 0 to mark a header and bit 1 to mark a tail: 01 is header, 00 is body, 10 is tail, 11 is a single-flit packet. A single-flit packet is routed and delivered as a complete packet.
- R2: A header leaves on the output port held in the table entry selected by the low DEST_W bits of its data (bits 1:0 by default). Body and tail flits follow that port without a lookup.
- R3: After reset, table entry d holds port d mod NP. When tbl_we is high at a clock edge, entry tbl_addr is set to tbl_port. Headers that arrive after the write use the new entry.
- R4: All flits of a packet leave a single output in their original order, one after another, with no flit of another packet placed between them.
- R5: Each output arbitrates round-robin among the inputs that request it. After input i is granted, the search for the next grant starts at input i+1. A grant is held until the tail flit has passed.
- R6: Packets bound for distinct outputs move at the same time. Once a packet's header has left with out_ready held high, the rest of the packet follows at one flit per cycle.
- R7: While out_valid is high and out_ready is low, that output's valid, type and data stay stable. An input buffer holds 10 flits, and in_ready goes low when the buffer is full. No flit is lost.
- R8: After reset, every out_valid is low and every in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NP | Flit offered on each input |
| in_type | input | NP x 2 | Flit type per input (bit 0 header, bit 1 tail) |
| in_data | input | NP x FLIT_W | Flit payload per input |
| in_ready | output | NP | Input buffer has room |
| out_valid | output | NP | Flit present on each output |
| out_type | output | NP x 2 | Flit type per output |
| out_data | output | NP x FLIT_W | Flit payload per output |
| out_ready | input | NP | Downstream accepts the output flit |
| tbl_we | input | 1 | Forwarding table write enable |
| tbl_addr | input | DEST_W | Destination entry to write |
| tbl_port | input | clog2(NP) | Output port stored in that entry |

## Verification
The assertions check four properties on every cycle:
- A stalled output holds its valid, type and data stable.
- Every accepted output flit keeps packets contiguous: a header appears only after a tail, and a non-header only inside an open packet.
- No input holds two output paths at once.
- Every header leaving an output matches the forwarding table entry for its destination.

Only the directed scenarios can show the remaining behaviour:
- the round-robin order between contending packets;
- the effect of a table write on later traffic;
- the one-flit-per-cycle rate of an unblocked packet;
- in_ready dropping once a buffer fills behind a stalled output.

// File: rtl/sw_pkg.sv
package sw_pkg;
    localparam int TYPE_W = 2;

    typedef enum logic [TYPE_W-1:0] {
        FK_BODY = 2'b00,
        FK_HEAD = 2'b01,
        FK_TAIL = 2'b10,
        FK_SOLO = 2'b11
    } flit_kind_e;

    function automatic logic kind_is_head(input logic [TYPE_W-1:0] t);
        return t[0];
    endfunction

    function automatic logic kind_is_tail(input logic [TYPE_W-1:0] t);
        return t[1];
    endfunction
endpackage

// File: rtl/sw_flit_fifo.sv
module sw_flit_fifo #(
    parameter int WIDTH = 66,
    parameter int DEPTH = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[st_q.rp];

    always_comb begin
        st_d = st_q;
        if (do_push) st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + AW'(1);
        if (do_pop)  st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + AW'(1);
        if (do_push && !do_pop)      st_d.cnt = st_q.cnt + CW'(1);
        else if (!do_push && do_pop) st_d.cnt = st_q.cnt - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wp] <= wdata;
    end
endmodule

// File: rtl/sw_rr_arb.sv
module sw_rr_arb #(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int k = 0; k < N; k++) begin
            if (!any && req[(int'(ptr) + k) % N]) begin
                any = 1'b1;
                idx = IW'((int'(ptr) + k) % N);
            end
        end
    end
endmodule

// File: rtl/sw_core.sv
module sw_core #(
    parameter int NP        = 4,
    parameter int FLIT_W    = 64,
    parameter int BUF_DEPTH = 10,
    parameter int DEST_W    = 2,
    localparam int PW       = $clog2(NP),
    localparam int TW       = sw_pkg::TYPE_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NP-1:0]                in_valid,
    input  logic [NP-1:0][TW-1:0]        in_type,
    input  logic [NP-1:0][FLIT_W-1:0]    in_data,
    output logic [NP-1:0]                in_ready,
    output logic [NP-1:0]                out_valid,
    output logic [NP-1:0][TW-1:0]        out_type,
    output logic [NP-1:0][FLIT_W-1:0]    out_data,
    input  logic [NP-1:0]                out_ready,
    input  logic                         tbl_we,
    input  logic [DEST_W-1:0]            tbl_addr,
    input  logic [PW-1:0]                tbl_port
);
    import sw_pkg::*;

    localparam int NDEST = 2 ** DEST_W;
    localparam int EW    = TW + FLIT_W;

    typedef struct packed {
        logic [NP-1:0]              rt_vld;
        logic [NP-1:0][PW-1:0]      rt_port;
        logic [NP-1:0]              lock;
        logic [NP-1:0][PW-1:0]      owner;
        logic [NP-1:0][PW-1:0]      ptr;
        logic [NP-1:0]              ov;
        logic [NP-1:0][TW-1:0]      otype;
        logic [NP-1:0][FLIT_W-1:0]  odata;
        logic [NDEST-1:0][PW-1:0]   tbl;
    } core_st_t;

    function automatic core_st_t reset_state();
        core_st_t s;
        s = '0;
        for (int k = 0; k < NDEST; k++) s.tbl[k] = PW'(k % NP);
        return s;
    endfunction

    localparam core_st_t RST_ST = reset_state();

    core_st_t st_d, st_q;

    logic [NP-1:0][EW-1:0]     rd;
    logic [NP-1:0][TW-1:0]     h_type;
    logic [NP-1:0][FLIT_W-1:0] h_data;
    logic [NP-1:0]             full, empty, pop;
    logic [NP-1:0][NP-1:0]     req;
    logic [NP-1:0]             g_any;
    logic [NP-1:0][PW-1:0]     g_idx;

    // Stage 1: input buffering
    for (genvar i = 0; i < NP; i++) begin : g_in
        sw_flit_fifo #(.WIDTH(EW), .DEPTH(BUF_DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (in_valid[i]),
            .wdata ({in_type[i], in_data[i]}),
            .pop   (pop[i]),
            .rdata (rd[i]),
            .full  (full[i]),
            .empty (empty[i])
        );
        assign h_type[i] = rd[i][EW-1 -: TW];
        assign h_data[i] = rd[i][FLIT_W-1:0];
    end

    assign in_ready = ~full;

    // Stage 3: per-output requests and round-robin arbiters
    always_comb begin
        for (int o = 0; o < NP; o++)
            for (int i = 0; i < NP; i++)
                req[o][i] = st_q.rt_vld[i] && !empty[i]
                          && (st_q.rt_port[i] == PW'(o)) && !st_q.lock[o];
    end

    for (genvar o = 0; o < NP; o++) begin : g_out
        sw_rr_arb #(.N(NP)) u_arb (
            .req (req[o]),
            .ptr (st_q.ptr[o]),
            .any (g_any[o]),
            .idx (g_idx[o])
        );
    end

    always_comb begin
        st_d = st_q;
        pop  = '0;
        // Stage 2: route lookup for a header at the buffer head
        for (int i = 0; i < NP; i++) begin
            if (!empty[i] && !st_q.rt_vld[i] && kind_is_head(h_type[i])) begin
                st_d.rt_vld[i]  = 1'b1;
                st_d.rt_port[i] = st_q.tbl[h_data[i][DEST_W-1:0]];
            end
        end
        for (int o = 0; o < NP; o++) begin
            // Stage 3: grant is taken and held until the tail
            if (g_any[o]) begin
                st_d.lock[o]  = 1'b1;
                st_d.owner[o] = g_idx[o];
                st_d.ptr[o]   = (g_idx[o] == PW'(NP - 1)) ? '0 : g_idx[o] + PW'(1);
            end
            if (st_q.ov[o] && out_ready[o]) st_d.ov[o] = 1'b0;
            // Stages 4 and 5: crossbar traversal into the output register
            if (st_q.lock[o] && !empty[st_q.owner[o]] && (!st_q.ov[o] || out_ready[o])) begin
                pop[st_q.owner[o]] = 1'b1;
                st_d.ov[o]    = 1'b1;
                st_d.otype[o] = h_type[st_q.owner[o]];
                st_d.odata[o] = h_data[st_q.owner[o]];
                if (kind_is_tail(h_type[st_q.owner[o]])) begin
                    st_d.lock[o]               = 1'b0;
                    st_d.rt_vld[st_q.owner[o]] = 1'b0;
                end
            end
        end
        if (tbl_we) st_d.tbl[tbl_addr] = tbl_port;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.ov;
    assign out_type  = st_q.otype;
    assign out_data  = st_q.odata;
endmodule

// File: rtl/sw_core_chk.sv
module sw_core_chk #(
    parameter int NP     = 4,
    parameter int FLIT_W = 64,
    parameter int DEST_W = 2,
    localparam int PW    = $clog2(NP),
    localparam int NDEST = 2 ** DEST_W
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NP-1:0]               out_valid,
    input logic [NP-1:0]               out_ready,
    input logic [NP-1:0][1:0]          out_type,
    input logic [NP-1:0][FLIT_W-1:0]   out_data,
    input logic [NP-1:0]               lock_q,
    input logic [NP-1:0][PW-1:0]       owner_q,
    input logic [NDEST-1:0][PW-1:0]    tbl_q
);
    logic [NP-1:0] pkt_open;

    always_ff @(posedge clk) begin
        if (!rst_n) pkt_open <= '0;
        else
            for (int o = 0; o < NP; o++)
                if (out_valid[o] && out_ready[o]) pkt_open[o] <= !out_type[o][1];
    end

    for (genvar o = 0; o < NP; o++) begin : g_o
        p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] && !out_ready[o] |=>
                out_valid[o] && $stable(out_type[o]) && $stable(out_data[o]));

        p_contiguous_r4: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] && out_ready[o] |-> (out_type[o][0] == !pkt_open[o]));

        p_route_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] && out_ready[o] && out_type[o][0] |->
                tbl_q[out_data[o][DEST_W-1:0]] == PW'(o));

        for (genvar b = o + 1; b < NP; b++) begin : g_b
            p_one_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
                lock_q[o] && lock_q[b] |-> owner_q[o] != owner_q[b]);
        end
    end
endmodule

bind sw_core sw_core_chk #(.NP(NP), .FLIT_W(FLIT_W), .DEST_W(DEST_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_type  (out_type),
    .out_data  (out_data),
    .lock_q    (st_q.lock),
    .owner_q   (st_q.owner),
    .tbl_q     (st_q.tbl)
);

// File: tb/test_sw_core.sv
module test_sw_core;
    localparam int NP = 4;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NP-1:0]        in_valid = '0;
    logic [NP-1:0][1:0]   in_type = '0;
    logic [NP-1:0][63:0]  in_data = '0;
    logic [NP-1:0]        in_ready;
    logic [NP-1:0]        out_valid;
    logic [NP-1:0][1:0]   out_type;
    logic [NP-1:0][63:0]  out_data;
    logic [NP-1:0]        out_ready = '1;
    logic                 tbl_we = 1'b0;
    logic [1:0]           tbl_addr = '0;
    logic [1:0]           tbl_port = '0;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    logic [1:0]  cap_t [NP][256];
    logic [63:0] cap_d [NP][256];
    int          cap_c [NP][256];
    int          cap_n [NP];

    sw_core i_sw_core (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_type(in_type), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_type(out_type), .out_data(out_data), .out_ready(out_ready),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_port(tbl_port)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial for (int o = 0; o < NP; o++) cap_n[o] = 0;

    always @(negedge clk) begin
        if (rst_n)
            for (int o = 0; o < NP; o++)
                if (out_valid[o] && out_ready[o] && cap_n[o] < 256) begin
                    cap_t[o][cap_n[o]] = out_type[o];
                    cap_d[o][cap_n[o]] = out_data[o];
                    cap_c[o][cap_n[o]] = cyc;
                    cap_n[o] = cap_n[o] + 1;
                end
    end

    function automatic logic [63:0] fdata(input logic [7:0] tag, input int k, input int dest);
        return {tag, 8'(k), 46'h0, 2'(dest)};
    endfunction

    function automatic logic [1:0] ftype(input int k, input int len);
        if (len == 1)      return 2'b11;
        if (k == 0)        return 2'b01;
        if (k == len - 1)  return 2'b10;
        return 2'b00;
    endfunction

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic send_pkt(input int p, input int dest, input int len, input logic [7:0] tag);
        for (int k = 0; k < len; k++) begin
            logic acc;
            in_valid[p] = 1'b1;
            in_type[p]  = ftype(k, len);
            in_data[p]  = fdata(tag, k, dest);
            acc = 1'b0;
            while (!acc) begin
                @(negedge clk);
                acc = in_ready[p];
                @(posedge clk);
                #2;
            end
        end
        in_valid[p] = 1'b0;
    endtask

    task automatic chk_pkt(input int o, input int s, input logic [7:0] tag, input int len,
                           input int dest, input string rq, input bit contig);
        for (int k = 0; k < len; k++) begin
            chk(rq, $sformatf("out%0d flit%0d type", o, k), 64'(cap_t[o][s + k]), 64'(ftype(k, len)));
            chk(rq, $sformatf("out%0d flit%0d data", o, k), cap_d[o][s + k], fdata(tag, k, dest));
            if (contig && k > 0)
                chk("R6", $sformatf("out%0d flit%0d spacing", o, k),
                    64'(cap_c[o][s + k] - cap_c[o][s + k - 1]), 64'd1);
        end
    endtask

    task automatic settle();
        repeat (30) @(posedge clk);
        #2;
    endtask

    task automatic write_tbl(input int a, input int p);
        tbl_we = 1'b1; tbl_addr = 2'(a); tbl_port = 2'(p);
        @(posedge clk); #2;
        tbl_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R8", "out_valid after reset", 64'(out_valid), 64'h0);
        chk("R8", "in_ready after reset", 64'(in_ready), 64'hF);
    endtask

    // R2, R3 default table, R4, R6 parallel traffic at full rate
    task automatic t_parallel();
        int s [NP];
        for (int o = 0; o < NP; o++) s[o] = cap_n[o];
        fork
            send_pkt(0, 1, 5, 8'h10);
            send_pkt(1, 2, 5, 8'h11);
            send_pkt(2, 3, 5, 8'h12);
            send_pkt(3, 0, 5, 8'h13);
        join
        settle();
        for (int i = 0; i < NP; i++) begin
            int o = (i + 1) % NP;
            chk("R3", $sformatf("out%0d count", o), 64'(cap_n[o] - s[o]), 64'd5);
            chk_pkt(o, s[o], 8'(8'h10 + i), 5, o, "R2", 1'b1);
        end
    endtask

    // R5: out2 last granted input 1, so input 3 is served before input 1
    task automatic t_contend();
        int s = cap_n[2];
        fork
            send_pkt(1, 2, 4, 8'h31);
            send_pkt(3, 2, 4, 8'h33);
        join
        settle();
        chk("R4", "out2 count", 64'(cap_n[2] - s), 64'd8);
        chk_pkt(2, s,     8'h33, 4, 2, "R5", 1'b0);
        chk_pkt(2, s + 4, 8'h31, 4, 2, "R4", 1'b0);
    endtask

    // R3: rewrite entry 0 to port 3 while idle
    task automatic t_table();
        int s0 = cap_n[0];
        int s3 = cap_n[3];
        write_tbl(0, 3);
        send_pkt(2, 0, 3, 8'h40);
        settle();
        chk("R3", "out0 untouched", 64'(cap_n[0] - s0), 64'd0);
        chk("R3", "out3 count", 64'(cap_n[3] - s3), 64'd3);
        chk_pkt(3, s3, 8'h40, 3, 0, "R3", 1'b1);
        write_tbl(0, 0);
    endtask

    // R7: stalled output, buffer fills, nothing lost
    task automatic t_backpressure();
        int s = cap_n[1];
        out_ready[1] = 1'b0;
        fork
            send_pkt(0, 1, 12, 8'h50);
            begin
                repeat (30) @(posedge clk);
                #2;
                chk("R7", "in_ready with full buffer", 64'(in_ready[0]), 64'd0);
                chk("R7", "out_valid while stalled", 64'(out_valid[1]), 64'd1);
                chk("R7", "held header", out_data[1], fdata(8'h50, 0, 1));
                repeat (5) @(posedge clk);
                #2;
                chk("R7", "header still held", out_data[1], fdata(8'h50, 0, 1));
                out_ready[1] = 1'b1;
            end
        join
        settle();
        chk("R7", "out1 count", 64'(cap_n[1] - s), 64'd12);
        chk_pkt(1, s, 8'h50, 12, 1, "R7", 1'b0);
    endtask

    // R1: single-flit packet followed by a two-flit packet
    task automatic t_single();
        int s = cap_n[0];
        send_pkt(3, 0, 1, 8'h60);
        send_pkt(3, 0, 2, 8'h61);
        settle();
        chk("R1", "out0 count", 64'(cap_n[0] - s), 64'd3);
        chk_pkt(0, s,     8'h60, 1, 0, "R1", 1'b0);
        chk_pkt(0, s + 1, 8'h61, 2, 0, "R1", 1'b0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2;
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        t_reset();
        t_parallel();
        t_contend();
        t_table();
        t_backpressure();
        t_single();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule